// File: doc/BRIEF.md
# Coalescing Interrupt Source State Engine

This block tracks the delivery state of a set of interrupt sources. Each source has a two-bit state made of a pending bit (P) and a queued bit (Q), plus an "asserted" flag for level-type sources. Three kinds of stimulus change that state: hardware lines, one per source; bus commands that trigger, end (EOI), set or read a source; and a reset. The two-bit state absorbs repeated events while a source is being serviced. A second event is remembered as "queued", and it fires again only when the handler signals end of interrupt. Level-type sources also fire again at EOI while their line is still high.

Each source is configured as edge/message type or level type through a configuration vector. Reset leaves that vector unchanged. Every event that must be forwarded enters a per-source notification counter. The notify port drains these counters one notification per cycle, lowest index first, so simultaneous events are serialised and none is dropped.

Top module: `irq_coalesce_engine`

## Requirements
- R1: While reset is low, and after it is released, every source's state is off (P=0,Q=1, value 01), the asserted flags are clear, and `ntf_valid_o`, `rsp_valid_o` and `err_o` are low.
- R2: Reset does not change the edge/level configuration. A source loaded as level type (bit set in `cfg_level_i` while `cfg_we_i` is high) stays level type across reset.
- R3: A trigger (a command with op 0, or a rising line on an edge source) acts as follows. Idle (00) moves to pending (10) and produces one notification. Pending or queued moves to queued (11) with no notification. Off stays off with no notification.
- R4: An EOI command (op 1) acts as follows. Idle or pending goes to idle with no notification. Queued goes to pending with one notification. Off stays off.
- R5: A set command (op 2) writes `cmd_pq_i` into the addressed source. A read command (op 3) changes nothing. For every command, `rsp_valid_o` pulses in the following cycle and `rsp_pq_o` carries the state the command found.
- R6: On an edge source, a falling line has no effect on state or notifications.
- R7: On a level source, a rising line sets the asserted flag. If that source was idle, it moves to pending and notifies; in any other state nothing else changes. A falling line clears only the asserted flag.
- R8: On a level source, the EOI transition is applied first. If the asserted flag is still set, the level rule of R7 then runs again, and the notification result comes from that second step alone. A queued source with its line high therefore goes to pending without notifying.
- R9: A trigger command that leaves a level source queued raises `err_o` for one cycle, in the cycle after the command. The same command on an edge source does not.
- R10: When a line edge and a command reach the same source in one cycle, the line is applied first and the command then acts on the result. Every notification produced by either step is delivered.
- R11: `ntf_valid_o` is high for exactly one cycle per notification, with `ntf_idx_o` naming the source. Pending notifications leave lowest index first, starting in the cycle after the event that produced them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Load the source type vector |
| cfg_level_i | input | NUM_SRC | Source type, 1 = level, 0 = edge/message |
| hw_line_i | input | NUM_SRC | Hardware interrupt lines |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | 0 trigger, 1 EOI, 2 set, 3 read |
| cmd_idx_i | input | IDX_W | Source addressed by the command |
| cmd_pq_i | input | 2 | New state for a set command, P in bit 1 |
| rsp_valid_o | output | 1 | Command response strobe |
| rsp_pq_o | output | 2 | State found by the command |
| err_o | output | 1 | Protocol error: level source queued by a trigger command |
| ntf_valid_o | output | 1 | Notification strobe |
| ntf_idx_o | output | IDX_W | Source being notified |

## Verification
The bench aims at the two places where a single event changes state twice. The first is EOI on an asserted level source. A design that kept the plain EOI result would notify a queued source instead of leaving it pending. A design that skipped the rerun would leave the source idle and lose the still-active line. The second is a line edge and a command on the same source in one cycle. A design that applied the command first would answer with the wrong state. A design that merged the two notifications of the same step would deliver one pulse instead of two. The bench also raises several lines at once to check ordered draining, and shows that off is sticky against triggers and EOIs.

// File: rtl/irq_pq_pkg.sv
package irq_pq_pkg;

    // P is bit 1, Q is bit 0
    localparam logic [1:0] PQ_IDLE   = 2'b00;
    localparam logic [1:0] PQ_OFF    = 2'b01;
    localparam logic [1:0] PQ_PEND   = 2'b10;
    localparam logic [1:0] PQ_QUEUED = 2'b11;

    localparam logic [1:0] OP_TRIG = 2'd0;
    localparam logic [1:0] OP_EOI  = 2'd1;
    localparam logic [1:0] OP_SET  = 2'd2;
    localparam logic [1:0] OP_READ = 2'd3;

    typedef struct packed {
        logic [1:0] pq;
        logic       fire;
    } step_t;

    function automatic step_t step_trigger(logic [1:0] pq);
        step_t r;
        r.fire = 1'b0;
        case (pq)
            PQ_IDLE:  begin r.pq = PQ_PEND; r.fire = 1'b1; end
            PQ_OFF:   r.pq = PQ_OFF;
            default:  r.pq = PQ_QUEUED;
        endcase
        return r;
    endfunction

    function automatic step_t step_eoi(logic [1:0] pq);
        step_t r;
        r.fire = 1'b0;
        case (pq)
            PQ_QUEUED: begin r.pq = PQ_PEND; r.fire = 1'b1; end
            PQ_OFF:    r.pq = PQ_OFF;
            default:   r.pq = PQ_IDLE;
        endcase
        return r;
    endfunction

    // level rule: only an idle source moves and fires
    function automatic step_t step_level(logic [1:0] pq);
        step_t r;
        r.pq   = pq;
        r.fire = 1'b0;
        if (pq == PQ_IDLE) begin
            r.pq   = PQ_PEND;
            r.fire = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_pq_slot.sv
module irq_pq_slot
    import irq_pq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       level_i,
    input  logic       line_i,
    input  logic       hit_i,
    input  logic [1:0] op_i,
    input  logic [1:0] set_pq_i,
    output logic [1:0] pq_o,
    output logic [1:0] seen_pq_o,
    output logic [1:0] ntf_cnt_o,
    output logic       proto_err_o
);

    typedef struct packed {
        logic [1:0] pq;
        logic       asserted;
        logic       line;
    } slot_t;

    slot_t st_q, st_d;

    logic       rise, fall;
    logic [1:0] pq_h, pq_c;
    logic       asr_h, n_h, n_c;
    step_t      s_h, s_c, s_r;

    always_comb begin
        rise  = line_i & ~st_q.line;
        fall  = ~line_i & st_q.line;
        pq_h  = st_q.pq;
        asr_h = st_q.asserted;
        n_h   = 1'b0;
        s_h   = step_trigger(st_q.pq);
        s_r   = step_level(st_q.pq);

        // stage 1: hardware line
        if (level_i) begin
            if (rise) begin
                asr_h = 1'b1;
                pq_h  = s_r.pq;
                n_h   = s_r.fire;
            end else if (fall) begin
                asr_h = 1'b0;
            end
        end else if (rise) begin
            pq_h = s_h.pq;
            n_h  = s_h.fire;
        end

        // stage 2: command on the post-line state
        pq_c        = pq_h;
        n_c         = 1'b0;
        proto_err_o = 1'b0;
        s_c         = '0;
        if (hit_i) begin
            case (op_i)
                OP_TRIG: begin
                    s_c         = step_trigger(pq_h);
                    pq_c        = s_c.pq;
                    n_c         = s_c.fire;
                    proto_err_o = level_i && (s_c.pq == PQ_QUEUED);
                end
                OP_EOI: begin
                    s_c  = step_eoi(pq_h);
                    pq_c = s_c.pq;
                    n_c  = s_c.fire;
                    if (level_i && asr_h) begin
                        s_c  = step_level(pq_c);
                        pq_c = s_c.pq;
                        n_c  = s_c.fire;
                    end
                end
                OP_SET:  pq_c = set_pq_i;
                default: pq_c = pq_h;
            endcase
        end

        st_d.pq       = pq_c;
        st_d.asserted = asr_h;
        st_d.line     = line_i;

        seen_pq_o = pq_h;
        ntf_cnt_o = {1'b0, n_h} + {1'b0, n_c};
        pq_o      = st_q.pq;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pq       <= PQ_OFF;
            st_q.asserted <= 1'b0;
            st_q.line     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/irq_ntf_queue.sv
module irq_ntf_queue #(
    parameter int NUM_SRC = 8,
    parameter int CNT_W   = 2,
    parameter int IDX_W   = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_SRC-1:0][1:0]        add_i,
    output logic                           valid_o,
    output logic [IDX_W-1:0]               idx_o
);

    localparam int SUM_W = CNT_W + 2;
    localparam logic [SUM_W-1:0] CNT_MAX = SUM_W'((1 << CNT_W) - 1);

    typedef struct packed {
        logic [NUM_SRC-1:0][CNT_W-1:0] cnt;
    } queue_t;

    queue_t q_q, q_d;
    logic [SUM_W-1:0] sum;

    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (q_q.cnt[i] != '0) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
        for (int i = 0; i < NUM_SRC; i++) begin
            sum = SUM_W'(q_q.cnt[i]) + SUM_W'(add_i[i]);
            if (valid_o && (idx_o == IDX_W'(i))) begin
                sum = sum - SUM_W'(1);
            end
            if (sum > CNT_MAX) begin
                sum = CNT_MAX;
            end
            q_d.cnt[i] = sum[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

endmodule

// File: rtl/irq_coalesce_engine.sv
module irq_coalesce_engine
    import irq_pq_pkg::*;
#(
    parameter int NUM_SRC   = 8,
    parameter int NTF_CNT_W = 2,
    localparam int IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we_i,
    input  logic [NUM_SRC-1:0] cfg_level_i,
    input  logic [NUM_SRC-1:0] hw_line_i,
    input  logic               cmd_valid_i,
    input  logic [1:0]         cmd_op_i,
    input  logic [IDX_W-1:0]   cmd_idx_i,
    input  logic [1:0]         cmd_pq_i,
    output logic               rsp_valid_o,
    output logic [1:0]         rsp_pq_o,
    output logic               err_o,
    output logic               ntf_valid_o,
    output logic [IDX_W-1:0]   ntf_idx_o
);

    typedef struct packed {
        logic       rsp_valid;
        logic [1:0] rsp_pq;
        logic       err;
    } top_t;

    top_t top_q, top_d;

    logic [NUM_SRC-1:0]      level_q;
    logic [NUM_SRC-1:0][1:0] pq_vec;
    logic [NUM_SRC-1:0][1:0] seen_vec;
    logic [NUM_SRC-1:0][1:0] ntf_add;
    logic [NUM_SRC-1:0]      err_vec;

    // type configuration is kept across reset on purpose
    always_ff @(posedge clk) begin
        if (cfg_we_i) begin
            level_q <= cfg_level_i;
        end
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
        irq_pq_slot u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .level_i     (level_q[g]),
            .line_i      (hw_line_i[g]),
            .hit_i       (cmd_valid_i && (cmd_idx_i == IDX_W'(g))),
            .op_i        (cmd_op_i),
            .set_pq_i    (cmd_pq_i),
            .pq_o        (pq_vec[g]),
            .seen_pq_o   (seen_vec[g]),
            .ntf_cnt_o   (ntf_add[g]),
            .proto_err_o (err_vec[g])
        );
    end

    irq_ntf_queue #(
        .NUM_SRC (NUM_SRC),
        .CNT_W   (NTF_CNT_W),
        .IDX_W   (IDX_W)
    ) u_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .add_i   (ntf_add),
        .valid_o (ntf_valid_o),
        .idx_o   (ntf_idx_o)
    );

    always_comb begin
        top_d.rsp_valid = cmd_valid_i;
        top_d.rsp_pq    = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (cmd_idx_i == IDX_W'(i)) begin
                top_d.rsp_pq = seen_vec[i];
            end
        end
        top_d.err = |err_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign rsp_valid_o = top_q.rsp_valid;
    assign rsp_pq_o    = top_q.rsp_pq;
    assign err_o       = top_q.err;

endmodule

// File: rtl/irq_coalesce_engine_chk.sv
module irq_coalesce_engine_chk
    import irq_pq_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cmd_valid_i,
    input logic [1:0]              cmd_op_i,
    input logic [IDX_W-1:0]        cmd_idx_i,
    input logic [1:0]              cmd_pq_i,
    input logic                    rsp_valid_o,
    input logic                    err_o,
    input logic                    ntf_valid_o,
    input logic [IDX_W-1:0]        ntf_idx_o,
    input logic [NUM_SRC-1:0][1:0] pq_vec
);

    logic [IDX_W-1:0] idx_q;
    logic [1:0]       val_q;
    always_ff @(posedge clk) begin
        idx_q <= cmd_idx_i;
        val_q <= cmd_pq_i;
    end

    // R1: first cycle out of reset shows no notification and no error
    p_reset_quiet_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!ntf_valid_o && !err_o && !rsp_valid_o));

    // R5: each command is answered in the next cycle, and only then
    p_rsp_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_i |=> rsp_valid_o);
    p_rsp_only_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid_i |=> !rsp_valid_o);

    // R5: a set command leaves the written value in the source
    p_set_writes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_op_i == OP_SET && 32'(cmd_idx_i) < NUM_SRC)
        |=> (pq_vec[idx_q] == val_q));

    // R9: the error flag only follows a trigger command
    p_err_after_trig_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(cmd_valid_i && cmd_op_i == OP_TRIG));

    // R11: notified index names an existing source
    p_ntf_idx_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ntf_valid_o |-> (32'(ntf_idx_o) < NUM_SRC));

    // R3: an off source leaves off only through a set command
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_off
        p_off_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (pq_vec[g] == PQ_OFF &&
             !(cmd_valid_i && cmd_op_i == OP_SET && cmd_idx_i == IDX_W'(g)))
            |=> (pq_vec[g] == PQ_OFF));
    end

endmodule

bind irq_coalesce_engine irq_coalesce_engine_chk #(
    .NUM_SRC (NUM_SRC),
    .IDX_W   (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .cmd_idx_i   (cmd_idx_i),
    .cmd_pq_i    (cmd_pq_i),
    .rsp_valid_o (rsp_valid_o),
    .err_o       (err_o),
    .ntf_valid_o (ntf_valid_o),
    .ntf_idx_o   (ntf_idx_o),
    .pq_vec      (pq_vec)
);

// File: tb/tb_irq_coalesce_engine.sv
module tb_irq_coalesce_engine;
    import irq_pq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 8;
    localparam int IW         = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we;
    logic [N-1:0]  cfg_level;
    logic [N-1:0]  hw_line;
    logic          cmd_valid;
    logic [1:0]    cmd_op;
    logic [IW-1:0] cmd_idx;
    logic [1:0]    cmd_pq;
    logic          rsp_valid;
    logic [1:0]    rsp_pq;
    logic          err;
    logic          ntf_valid;
    logic [IW-1:0] ntf_idx;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_coalesce_engine #(.NUM_SRC(N)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we_i    (cfg_we),
        .cfg_level_i (cfg_level),
        .hw_line_i   (hw_line),
        .cmd_valid_i (cmd_valid),
        .cmd_op_i    (cmd_op),
        .cmd_idx_i   (cmd_idx),
        .cmd_pq_i    (cmd_pq),
        .rsp_valid_o (rsp_valid),
        .rsp_pq_o    (rsp_pq),
        .err_o       (err),
        .ntf_valid_o (ntf_valid),
        .ntf_idx_o   (ntf_idx)
    );

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_ntf(string req, bit v, int idx);
        chk({req, " ntf_valid"}, int'(ntf_valid), int'(v));
        if (v) chk({req, " ntf_idx"}, int'(ntf_idx), idx);
    endtask

    task automatic cmd(logic [1:0] op, int idx, logic [1:0] pq);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_idx   = IW'(idx);
        cmd_pq    = pq;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic line(int idx, bit v);
        hw_line[idx] = v;
        @(negedge clk);
    endtask

    task automatic expect_pq(string req, int idx, logic [1:0] exp);
        cmd(OP_READ, idx, 2'b00);
        chk({req, " state"}, int'(rsp_pq), int'(exp));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 ntf after reset", int'(ntf_valid), 0);
        chk("R1 err after reset", int'(err), 0);
        chk("R1 rsp after reset", int'(rsp_valid), 0);
        expect_pq("R1", 0, PQ_OFF);
        expect_pq("R1", N-1, PQ_OFF);
    endtask

    task automatic t_edge_flow();
        cmd(OP_SET, 2, PQ_IDLE);
        chk("R5 set returns old", int'(rsp_pq), int'(PQ_OFF));
        chk("R5 rsp strobe", int'(rsp_valid), 1);
        line(2, 1);
        expect_ntf("R3 idle trigger", 1, 2);
        expect_pq("R3", 2, PQ_PEND);
        line(2, 0);
        expect_ntf("R6 falling edge", 0, 0);
        expect_pq("R6", 2, PQ_PEND);
        line(2, 1);
        expect_ntf("R3 pending trigger", 0, 0);
        expect_pq("R3 queued", 2, PQ_QUEUED);
        cmd(OP_EOI, 2, 2'b00);
        expect_ntf("R4 eoi queued", 1, 2);
        expect_pq("R4 back to pending", 2, PQ_PEND);
        cmd(OP_EOI, 2, 2'b00);
        expect_ntf("R4 eoi pending", 0, 0);
        expect_pq("R4 idle", 2, PQ_IDLE);
        line(2, 0);
        expect_pq("R6 fall in idle", 2, PQ_IDLE);
    endtask

    task automatic t_off();
        cmd(OP_TRIG, 4, 2'b00);
        expect_ntf("R3 off trigger", 0, 0);
        expect_pq("R3 off", 4, PQ_OFF);
        line(4, 1);
        expect_ntf("R3 off line", 0, 0);
        line(4, 0);
        cmd(OP_EOI, 4, 2'b00);
        expect_ntf("R4 off eoi", 0, 0);
        expect_pq("R4 off", 4, PQ_OFF);
    endtask

    task automatic t_set();
        cmd(OP_SET, 4, PQ_QUEUED);
        chk("R5 old off", int'(rsp_pq), int'(PQ_OFF));
        cmd(OP_SET, 4, PQ_IDLE);
        chk("R5 old queued", int'(rsp_pq), int'(PQ_QUEUED));
        expect_pq("R5 read", 4, PQ_IDLE);
        expect_pq("R5 read unchanged", 4, PQ_IDLE);
        expect_ntf("R5 no notify", 0, 0);
    endtask

    task automatic t_level();
        cmd(OP_SET, 5, PQ_IDLE);
        line(5, 1);
        expect_ntf("R7 rise idle", 1, 5);
        expect_pq("R7", 5, PQ_PEND);
        cmd(OP_EOI, 5, 2'b00);
        expect_ntf("R8 eoi refire", 1, 5);
        expect_pq("R8", 5, PQ_PEND);
        line(5, 0);
        expect_ntf("R7 fall", 0, 0);
        expect_pq("R7 fall keeps state", 5, PQ_PEND);
        cmd(OP_EOI, 5, 2'b00);
        expect_ntf("R8 eoi deasserted", 0, 0);
        expect_pq("R8 idle", 5, PQ_IDLE);
        cmd(OP_SET, 5, PQ_PEND);
        line(5, 1);
        expect_ntf("R7 rise non-idle", 0, 0);
        expect_pq("R7 non-idle", 5, PQ_PEND);
        cmd(OP_SET, 5, PQ_QUEUED);
        cmd(OP_EOI, 5, 2'b00);
        expect_ntf("R8 queued asserted", 0, 0);
        expect_pq("R8 queued to pending", 5, PQ_PEND);
        line(5, 0);
        cmd(OP_EOI, 5, 2'b00);
        expect_pq("R8 cleanup", 5, PQ_IDLE);
    endtask

    task automatic t_proto_err();
        cmd(OP_TRIG, 5, 2'b00);
        expect_ntf("R3 cmd trigger", 1, 5);
        chk("R9 no err pending", int'(err), 0);
        cmd(OP_TRIG, 5, 2'b00);
        chk("R9 level queued err", int'(err), 1);
        expect_pq("R9", 5, PQ_QUEUED);
        chk("R9 err one cycle", int'(err), 0);
        cmd(OP_EOI, 5, 2'b00);
        expect_ntf("R4 level eoi queued", 1, 5);
        cmd(OP_EOI, 5, 2'b00);
        expect_pq("R9 cleanup", 5, PQ_IDLE);
        cmd(OP_TRIG, 2, 2'b00);
        cmd(OP_TRIG, 2, 2'b00);
        chk("R9 edge no err", int'(err), 0);
        cmd(OP_EOI, 2, 2'b00);
        cmd(OP_EOI, 2, 2'b00);
        expect_pq("R9 edge cleanup", 2, PQ_IDLE);
    endtask

    task automatic t_same_cycle();
        cmd(OP_SET, 1, PQ_IDLE);
        hw_line[1] = 1'b1;
        cmd(OP_EOI, 1, 2'b00);
        chk("R10 cmd sees post-line state", int'(rsp_pq), int'(PQ_PEND));
        expect_ntf("R10 edge notify", 1, 1);
        expect_pq("R10 edge final", 1, PQ_IDLE);
        expect_ntf("R10 single notify", 0, 0);
        line(1, 0);
        hw_line[5] = 1'b1;
        cmd(OP_EOI, 5, 2'b00);
        expect_ntf("R10 level first", 1, 5);
        expect_pq("R10 level final", 5, PQ_PEND);
        expect_ntf("R10 level second", 1, 5);
        @(negedge clk);
        expect_ntf("R10 drained", 0, 0);
        line(5, 0);
        cmd(OP_EOI, 5, 2'b00);
    endtask

    task automatic t_multi();
        cmd(OP_SET, 0, PQ_IDLE);
        cmd(OP_SET, 3, PQ_IDLE);
        cmd(OP_SET, 6, PQ_IDLE);
        hw_line[0] = 1'b1;
        hw_line[3] = 1'b1;
        hw_line[6] = 1'b1;
        @(negedge clk);
        expect_ntf("R11 first", 1, 0);
        @(negedge clk);
        expect_ntf("R11 second", 1, 3);
        @(negedge clk);
        expect_ntf("R11 third", 1, 6);
        @(negedge clk);
        expect_ntf("R11 empty", 0, 0);
        hw_line = '0;
        @(negedge clk);
    endtask

    task automatic t_cfg_keep();
        do_reset();
        chk("R1 ntf", int'(ntf_valid), 0);
        expect_pq("R1 after second reset", 5, PQ_OFF);
        expect_pq("R1 after second reset", 2, PQ_OFF);
        cmd(OP_SET, 5, PQ_IDLE);
        line(5, 1);
        expect_ntf("R2 level kept rise", 1, 5);
        cmd(OP_EOI, 5, 2'b00);
        expect_ntf("R2 level kept refire", 1, 5);
        line(5, 0);
    endtask

    initial begin
        rst_n     = 1'b0;
        cfg_we    = 1'b1;
        cfg_level = N'(1) << 5;
        hw_line   = '0;
        cmd_valid = 1'b0;
        cmd_op    = OP_READ;
        cmd_idx   = '0;
        cmd_pq    = '0;
        @(negedge clk);
        cfg_we = 1'b0;
        do_reset();
        t_reset();
        t_edge_flow();
        t_off();
        t_set();
        t_level();
        t_proto_err();
        t_same_cycle();
        t_multi();
        t_cfg_keep();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule